// File: doc/BRIEF.md
# DDR2 Bank State and Command Timing Guard

This block watches the command stream that a memory controller's scheduler sends toward a DDR2 device. It keeps a record for each of eight banks: whether a row is open, which row that is, and how many clocks remain on each bank's timing windows. Every clock it examines the single command offered to it, decides whether the command is legal, and reports that verdict one cycle later. The verdict carries a reason code that names the first rule the command broke. Commands judged illegal leave all state untouched. The scheduler can use the verdict to catch its own mistakes, or a system can use it to check a scheduler.

The timing windows are loaded from configuration inputs counted in clocks: row-to-column delay, precharge time, minimum row-active time and the refresh interval. The latency settings give the read and write latencies. A column command with its auto-precharge bit set may be issued before the row-active minimum has run out. The block then keeps the bank open and closes it once that minimum is met, and it does not flag the command. A refresh timer raises a request once the configured interval has passed since the last accepted refresh.

Top module: `ddr2_bank_guard`

## Requirements
- R1: An accepted activate (op 1) opens the bank named by the 3-bit bank input and stores the 14-bit address as its row. In the next cycle, bit b of `bank_open` is set and `bank_row[14*b+13:14*b]` holds the row. After reset, all banks are closed.
- R2: A read (op 2) or write (op 3) is rejected with reason 2 in either of two cases: the bank is closed, or the bank is waiting on a pending auto-precharge. An activate to a bank that is open is rejected with reason 3.
- R3: A read or write issued k cycles after the activate of its bank is rejected with reason 4 when k < tRCD − AL.
- R4: An activate issued k cycles after its bank was precharged, by any means, is rejected with reason 5 when k < tRP.
- R5: A precharge (op 4) to an open bank issued fewer than tRAS cycles after its activate is rejected with reason 6. A precharge to a closed bank is accepted and changes nothing.
- R6: A read or write with address bit 10 set is accepted when otherwise legal. Let c be the cycle of that command and a the cycle of the activate. The bank's internal precharge then takes place in cycle max(c+1, a+tRAS), and the bank reads closed from the next cycle.
- R7: CAS latency must be 3 to 6 and additive latency 0 to 5. While either setting is outside its range, every non-NOP command is rejected with reason 1. `rd_lat` = AL+CL and `wr_lat` = AL+CL−1, both registered.
- R8: A read or write issued fewer than BL/2 cycles after the last accepted read or write to any bank is rejected with reason 7. BL is 8 when `cfg_bl8` is 1 and 4 otherwise.
- R9: An accepted precharge-all (op 5) closes every bank and restarts the tRP window of all eight banks in the same cycle, including banks that were already closed. It is rejected with reason 6 if any open bank has not met tRAS.
- R10: Auto refresh (op 6) is rejected with reason 3 while any bank is open. It is rejected with reason 5 while any bank is still inside its tRP window.
- R11: Counting from 0 at the first cycle after reset release or after an accepted refresh, `ref_due` is high once the count reaches `cfg_trefi`. The count returns to zero on an accepted refresh.
- R12: The verdict for a command offered in cycle c appears in cycle c+1, with `res_valid` high (ops 0 and 7 are no-ops and give no verdict). Accepted commands report reason 0. When several rules are broken, the reason reported follows this order: configuration first, then bank state, then timing. A rejected command changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command opcode offered this cycle |
| cmd_bank | input | 3 | Bank index |
| cmd_addr | input | 14 | Row on activate; bit 10 is auto-precharge on read/write |
| cfg_cl | input | 3 | CAS latency in clocks |
| cfg_al | input | 3 | Additive latency in clocks |
| cfg_bl8 | input | 1 | 1 selects burst of 8, 0 burst of 4 |
| cfg_trcd | input | 5 | Activate-to-column delay in clocks |
| cfg_trp | input | 5 | Precharge time in clocks |
| cfg_tras | input | 5 | Minimum row-active time in clocks |
| cfg_trefi | input | 16 | Refresh interval in clocks |
| res_valid | output | 1 | A verdict is present |
| res_ok | output | 1 | The command was accepted |
| res_reason | output | 3 | Reason code, 0 when accepted |
| bank_open | output | 8 | One bit per bank, set while a row is open |
| bank_row | output | 112 | Open row of each bank, 14 bits per bank |
| rd_lat | output | 4 | Read latency in clocks |
| wr_lat | output | 4 | Write latency in clocks |
| ref_due | output | 1 | Refresh interval has expired |

## Verification
The hardest state to reach from the ports is the window in which an auto-precharge is pending but tRAS still holds the row open. The bank still reads open, yet it refuses column commands and activates. The bench gets there by issuing the activate, then a read with bit 10 set exactly tRCD later while tRAS is well above tRCD. It then probes the bank every cycle up to the close: it sends a plain read to test priority against the burst-spacing rule, and it watches `bank_open` on the cycle before and the cycle of the close. It then runs the same command issued long after tRAS has elapsed, to cover the case where the close follows on the next cycle.

// File: rtl/ddr2_guard_pkg.sv
package ddr2_guard_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_PREA = 3'd5,
    OP_REF  = 3'd6,
    OP_RSV  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    RS_OK    = 3'd0,
    RS_CFG   = 3'd1,
    RS_NOROW = 3'd2,
    RS_OPEN  = 3'd3,
    RS_TRCD  = 3'd4,
    RS_TRP   = 3'd5,
    RS_TRAS  = 3'd6,
    RS_BUS   = 3'd7
  } reason_e;
endpackage

// File: rtl/ddr2_bank_slot.sv
module ddr2_bank_slot #(
  parameter int ROW_W = 14,
  parameter int TW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TW-1:0]    cfg_trcd,
  input  logic [TW-1:0]    cfg_trp,
  input  logic [TW-1:0]    cfg_tras,
  input  logic             act_i,
  input  logic [ROW_W-1:0] act_row_i,
  input  logic             close_i,
  input  logic             ap_i,
  output logic             open_o,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o,
  output logic [TW-1:0]    trcd_left_o,
  output logic [TW-1:0]    trp_left_o,
  output logic [TW-1:0]    tras_left_o
);
  function automatic logic [TW-1:0] step_down(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic ap_fire;
  assign ap_fire = pend_o && (tras_left_o == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_o      <= 1'b0;
      pend_o      <= 1'b0;
      row_o       <= '0;
      trcd_left_o <= '0;
      trp_left_o  <= '0;
      tras_left_o <= '0;
    end else begin
      trcd_left_o <= step_down(trcd_left_o);
      trp_left_o  <= step_down(trp_left_o);
      tras_left_o <= step_down(tras_left_o);
      if (act_i) begin
        open_o      <= 1'b1;
        pend_o      <= 1'b0;
        row_o       <= act_row_i;
        trcd_left_o <= step_down(cfg_trcd);
        tras_left_o <= step_down(cfg_tras);
      end else if (close_i || ap_fire) begin
        open_o     <= 1'b0;
        pend_o     <= 1'b0;
        trp_left_o <= step_down(cfg_trp);
      end else if (ap_i) begin
        pend_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ddr2_latency_cfg.sv
module ddr2_latency_cfg #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic [2:0]    cfg_cl,
  input  logic [2:0]    cfg_al,
  output logic          cfg_ok,
  output logic [LW-1:0] rd_lat,
  output logic [LW-1:0] wr_lat
);
  logic [LW-1:0] sum;
  assign sum    = LW'(cfg_al) + LW'(cfg_cl);
  assign cfg_ok = (cfg_cl >= 3'd3) && (cfg_cl <= 3'd6) && (cfg_al <= 3'd5);

  always_ff @(posedge clk) begin
    rd_lat <= sum;
    wr_lat <= sum - 1'b1;
  end
endmodule

// File: rtl/ddr2_refresh_timer.sv
module ddr2_refresh_timer #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] cfg_trefi,
  input  logic          refresh_i,
  output logic          due_o
);
  logic [RW-1:0] elapsed, elapsed_nx;

  always_comb begin
    if (refresh_i)            elapsed_nx = '0;
    else if (elapsed == '1)   elapsed_nx = elapsed;
    else                      elapsed_nx = elapsed + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
      due_o   <= 1'b0;
    end else begin
      elapsed <= elapsed_nx;
      due_o   <= (elapsed_nx >= cfg_trefi);
    end
  end
endmodule

// File: rtl/ddr2_bank_guard.sv
module ddr2_bank_guard
  import ddr2_guard_pkg::*;
#(
  parameter  int NB     = 8,
  parameter  int ROW_W  = 14,
  parameter  int AP_BIT = 10,
  parameter  int TW     = 5,
  parameter  int RW     = 16,
  parameter  int LW     = 4,
  localparam int BA_W   = $clog2(NB)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          cmd_op,
  input  logic [BA_W-1:0]     cmd_bank,
  input  logic [ROW_W-1:0]    cmd_addr,
  input  logic [2:0]          cfg_cl,
  input  logic [2:0]          cfg_al,
  input  logic                cfg_bl8,
  input  logic [TW-1:0]       cfg_trcd,
  input  logic [TW-1:0]       cfg_trp,
  input  logic [TW-1:0]       cfg_tras,
  input  logic [RW-1:0]       cfg_trefi,
  output logic                res_valid,
  output logic                res_ok,
  output logic [2:0]          res_reason,
  output logic [NB-1:0]       bank_open,
  output logic [NB*ROW_W-1:0] bank_row,
  output logic [LW-1:0]       rd_lat,
  output logic [LW-1:0]       wr_lat,
  output logic                ref_due
);
  localparam int GW = 3;

  op_e           op;
  reason_e       verdict;
  logic          cfg_ok, is_cmd, legal, is_col;
  logic [NB-1:0] b_pend, trp_nz, tras_nz, act_v, close_v, ap_v;
  logic [TW-1:0] trcd_left [NB];
  logic [TW-1:0] trp_left  [NB];
  logic [TW-1:0] tras_left [NB];
  logic [GW-1:0] gap_left;

  assign op     = op_e'(cmd_op);
  assign is_cmd = (op != OP_NOP) && (op != OP_RSV);
  assign is_col = (op == OP_RD) || (op == OP_WR);

  ddr2_latency_cfg #(.LW(LW)) u_lat (
    .clk(clk), .cfg_cl(cfg_cl), .cfg_al(cfg_al),
    .cfg_ok(cfg_ok), .rd_lat(rd_lat), .wr_lat(wr_lat)
  );

  always_comb begin
    verdict = RS_OK;
    unique case (op)
      OP_ACT: begin
        if (bank_open[cmd_bank])    verdict = RS_OPEN;
        else if (trp_nz[cmd_bank])  verdict = RS_TRP;
      end
      OP_RD, OP_WR: begin
        if (!bank_open[cmd_bank] || b_pend[cmd_bank]) verdict = RS_NOROW;
        else if (trcd_left[cmd_bank] > TW'(cfg_al))    verdict = RS_TRCD;
        else if (gap_left != '0)                       verdict = RS_BUS;
      end
      OP_PRE:  if (bank_open[cmd_bank] && tras_nz[cmd_bank]) verdict = RS_TRAS;
      OP_PREA: if (|(bank_open & tras_nz))                   verdict = RS_TRAS;
      OP_REF: begin
        if (|bank_open)    verdict = RS_OPEN;
        else if (|trp_nz)  verdict = RS_TRP;
      end
      default: verdict = RS_OK;
    endcase
    if (is_cmd && !cfg_ok) verdict = RS_CFG;
  end

  assign legal = is_cmd && (verdict == RS_OK);

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic hit;
    assign hit        = (cmd_bank == BA_W'(i));
    assign act_v[i]   = legal && (op == OP_ACT) && hit;
    assign close_v[i] = legal && (((op == OP_PRE) && hit && bank_open[i]) || (op == OP_PREA));
    assign ap_v[i]    = legal && is_col && hit && cmd_addr[AP_BIT];
    assign trp_nz[i]  = (trp_left[i] != '0);
    assign tras_nz[i] = (tras_left[i] != '0);

    ddr2_bank_slot #(.ROW_W(ROW_W), .TW(TW)) u_slot (
      .clk(clk), .rst(rst),
      .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_tras(cfg_tras),
      .act_i(act_v[i]), .act_row_i(cmd_addr),
      .close_i(close_v[i]), .ap_i(ap_v[i]),
      .open_o(bank_open[i]), .pend_o(b_pend[i]),
      .row_o(bank_row[i*ROW_W +: ROW_W]),
      .trcd_left_o(trcd_left[i]), .trp_left_o(trp_left[i]),
      .tras_left_o(tras_left[i])
    );
  end

  ddr2_refresh_timer #(.RW(RW)) u_ref (
    .clk(clk), .rst(rst), .cfg_trefi(cfg_trefi),
    .refresh_i(legal && (op == OP_REF)), .due_o(ref_due)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_left   <= '0;
      res_valid  <= 1'b0;
      res_ok     <= 1'b0;
      res_reason <= RS_OK;
    end else begin
      if (legal && is_col) gap_left <= cfg_bl8 ? GW'(3) : GW'(1);
      else if (gap_left != '0) gap_left <= gap_left - 1'b1;
      res_valid  <= is_cmd;
      res_ok     <= legal;
      res_reason <= is_cmd ? verdict : RS_OK;
    end
  end
endmodule

// File: rtl/ddr2_bank_guard_chk.sv
module ddr2_bank_guard_chk #(
  parameter int NB    = 8,
  parameter int BA_W  = 3,
  parameter int ROW_W = 14,
  parameter int RW    = 16,
  parameter int LW    = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [2:0]          cmd_op,
  input logic [BA_W-1:0]     cmd_bank,
  input logic [ROW_W-1:0]    cmd_addr,
  input logic [2:0]          cfg_cl,
  input logic [2:0]          cfg_al,
  input logic [RW-1:0]       cfg_trefi,
  input logic                res_valid,
  input logic                res_ok,
  input logic [2:0]          res_reason,
  input logic [NB-1:0]       bank_open,
  input logic [NB*ROW_W-1:0] bank_row,
  input logic [LW-1:0]       rd_lat,
  input logic [LW-1:0]       wr_lat,
  input logic                ref_due
);
  logic [2:0]       p_op;
  logic [BA_W-1:0]  p_bank;
  logic [ROW_W-1:0] p_addr;
  logic [NB-1:0]    p_open;
  logic             p_cfgbad, p_live;
  logic [LW-1:0]    p_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_op <= 3'd0; p_bank <= '0; p_addr <= '0; p_open <= '0;
      p_cfgbad <= 1'b0; p_live <= 1'b0; p_sum <= '0;
    end else begin
      p_op     <= cmd_op;
      p_bank   <= cmd_bank;
      p_addr   <= cmd_addr;
      p_open   <= bank_open;
      p_cfgbad <= (cfg_cl < 3'd3) || (cfg_cl > 3'd6) || (cfg_al > 3'd5);
      p_live   <= 1'b1;
      p_sum    <= LW'(cfg_cl) + LW'(cfg_al);
    end
  end

  assert_act_opens_R1: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ok && p_op == 3'd1) |->
      (bank_open[p_bank] && bank_row[p_bank*ROW_W +: ROW_W] == p_addr));

  assert_col_needs_row_R2: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ok && (p_op == 3'd2 || p_op == 3'd3)) |-> p_open[p_bank]);

  assert_cfg_reject_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && p_cfgbad) |-> (!res_ok && res_reason == 3'd1));

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    p_live |-> (rd_lat == p_sum && wr_lat == p_sum - 1'b1));

  assert_prea_closes_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ok && p_op == 3'd5) |-> (bank_open == '0));

  assert_ref_closed_R10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ok && p_op == 3'd6) |-> (p_open == '0));

  assert_ref_clears_R11: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ok && p_op == 3'd6 && cfg_trefi != '0) |-> !ref_due);
endmodule

bind ddr2_bank_guard ddr2_bank_guard_chk #(
  .NB(NB), .BA_W(BA_W), .ROW_W(ROW_W), .RW(RW), .LW(LW)
) u_chk (
  .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
  .cmd_addr(cmd_addr), .cfg_cl(cfg_cl), .cfg_al(cfg_al),
  .cfg_trefi(cfg_trefi), .res_valid(res_valid), .res_ok(res_ok),
  .res_reason(res_reason), .bank_open(bank_open), .bank_row(bank_row),
  .rd_lat(rd_lat), .wr_lat(wr_lat), .ref_due(ref_due)
);

// File: tb/test_ddr2_bank_guard.sv
module test_ddr2_bank_guard;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   cmd_op = 3'd0;
  logic [2:0]   cmd_bank = 3'd0;
  logic [13:0]  cmd_addr = '0;
  logic [2:0]   cfg_cl = 3'd4;
  logic [2:0]   cfg_al = 3'd0;
  logic         cfg_bl8 = 1'b0;
  logic [4:0]   cfg_trcd = 5'd4;
  logic [4:0]   cfg_trp = 5'd3;
  logic [4:0]   cfg_tras = 5'd9;
  logic [15:0]  cfg_trefi = 16'd1000;
  logic         res_valid, res_ok, ref_due;
  logic [2:0]   res_reason;
  logic [7:0]   bank_open;
  logic [111:0] bank_row;
  logic [3:0]   rd_lat, wr_lat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ddr2_bank_guard i_ddr2_bank_guard (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cfg_cl(cfg_cl), .cfg_al(cfg_al),
    .cfg_bl8(cfg_bl8), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp),
    .cfg_tras(cfg_tras), .cfg_trefi(cfg_trefi), .res_valid(res_valid),
    .res_ok(res_ok), .res_reason(res_reason), .bank_open(bank_open),
    .bank_row(bank_row), .rd_lat(rd_lat), .wr_lat(wr_lat), .ref_due(ref_due)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic chk_res(input string rq, input int ok, input int reason);
    chk({rq, " valid"}, int'(res_valid), 1);
    chk({rq, " ok"}, int'(res_ok), ok);
    chk({rq, " reason"}, int'(res_reason), reason);
  endtask

  // present a command for one cycle; returns in the next cycle, away from the edge
  task automatic cmd(input int op, input int bk, input int addr);
    cmd_op = 3'(op); cmd_bank = 3'(bk); cmd_addr = 14'(addr);
    @(negedge clk);
    cmd_op = 3'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int row_of(input int b);
    return int'(bank_row[b*14 +: 14]);
  endfunction

  task automatic t_reset;
    chk("R1 reset banks closed", int'(bank_open), 0);
    chk("R12 reset no verdict", int'(res_valid), 0);
    chk("R11 reset no refresh due", int'(ref_due), 0);
    chk("R7 rd_lat", int'(rd_lat), 4);
    chk("R7 wr_lat", int'(wr_lat), 3);
  endtask

  task automatic t_basic;
    cmd(1, 2, 14'h1ABC);                 // cycle a
    chk_res("R1 act", 1, 0);
    chk("R1 open bit", int'(bank_open[2]), 1);
    chk("R1 row", row_of(2), 14'h1ABC);
    idle(2);
    cmd(2, 2, 0);                        // a+3, before tRCD
    chk_res("R3 early read", 0, 4);
    cmd(2, 2, 0);                        // a+4
    chk_res("R3 read at tRCD", 1, 0);
    cmd(2, 2, 0);                        // a+5, inside BL4 spacing
    chk_res("R8 burst spacing BL4", 0, 7);
    cmd(3, 2, 0);                        // a+6
    chk_res("R8 write after spacing", 1, 0);
    cmd(4, 2, 0);                        // a+7, before tRAS
    chk_res("R5 early precharge", 0, 6);
    idle(1);
    cmd(4, 2, 0);                        // a+9
    chk_res("R5 precharge at tRAS", 1, 0);
    chk("R5 bank closed", int'(bank_open[2]), 0);
    cmd(1, 2, 14'h55);                   // a+10
    chk_res("R4 activate inside tRP", 0, 5);
    idle(1);
    cmd(1, 2, 14'h55);                   // a+12
    chk_res("R4 activate at tRP", 1, 0);
    cmd(1, 2, 14'h66);
    chk_res("R2 activate open bank", 0, 3);
    chk("R12 rejected activate keeps row", row_of(2), 14'h55);
    cmd(2, 5, 0);
    chk_res("R2 read closed bank", 0, 2);
    cmd(4, 5, 0);
    chk_res("R5 precharge closed bank", 1, 0);
    chk("R5 closed-bank precharge no change", int'(bank_open), 8'b0000_0100);
  endtask

  task automatic t_autopre;
    cmd(1, 4, 14'h0123);                 // a
    idle(3);
    cmd(2, 4, 14'h0400);                 // a+4, auto-precharge
    chk_res("R6 auto-precharge read accepted", 1, 0);
    cmd(2, 4, 0);                        // a+5, pending beats spacing
    chk_res("R2 R12 read while auto-precharge pending", 0, 2);
    idle(3);                             // now a+9
    chk("R6 held open by tRAS", int'(bank_open[4]), 1);
    idle(1);                             // a+10
    chk("R6 closed after tRAS", int'(bank_open[4]), 0);
    cmd(1, 4, 14'h0200);                 // a+10
    chk_res("R6 R4 tRP after internal precharge", 0, 5);
    idle(1);
    cmd(1, 4, 14'h0200);                 // a+12
    chk_res("R6 activate after internal tRP", 1, 0);
    cmd(1, 6, 14'h3FFF);                 // b
    idle(11);
    cmd(3, 6, 14'h0400);                 // b+12, tRAS long met
    chk_res("R6 late auto-precharge write", 1, 0);
    chk("R6 open in cycle after command", int'(bank_open[6]), 1);
    idle(1);
    chk("R6 closed one cycle later", int'(bank_open[6]), 0);
  endtask

  task automatic t_prea;
    cmd(1, 0, 14'h0001);                 // p
    cmd(5, 0, 0);                        // p+1
    chk_res("R9 precharge-all before tRAS", 0, 6);
    chk("R12 rejected precharge-all no change", int'(bank_open), 8'b0001_0101);
    idle(8);
    cmd(5, 0, 0);                        // p+10
    chk_res("R9 precharge-all", 1, 0);
    chk("R9 all banks closed", int'(bank_open), 0);
    cmd(1, 7, 14'h0007);                 // p+11, bank 7 was never open
    chk_res("R9 tRP restarted on closed bank", 0, 5);
    idle(1);
    cmd(1, 7, 14'h0007);                 // p+13
    chk_res("R9 activate after tRP", 1, 0);
  endtask

  task automatic t_refresh;
    cfg_trefi = 16'd20;
    cmd(6, 0, 0);                        // p+14
    chk_res("R10 refresh with open bank", 0, 3);
    chk("R11 due after long interval", int'(ref_due), 1);
    idle(7);
    cmd(4, 7, 0);                        // p+22
    chk_res("R10 close bank", 1, 0);
    cmd(6, 0, 0);                        // p+23
    chk_res("R10 refresh inside tRP", 0, 5);
    idle(1);
    cmd(6, 0, 0);                        // r = p+25
    chk_res("R10 refresh accepted", 1, 0);
    chk("R11 cleared by refresh", int'(ref_due), 0);
    idle(19);                            // r+20, count 19
    chk("R11 not yet due", int'(ref_due), 0);
    idle(1);                             // r+21, count 20
    chk("R11 due at interval", int'(ref_due), 1);
    cfg_trefi = 16'd60000;
  endtask

  task automatic t_cfg;
    cfg_cl = 3'd7;
    cmd(1, 1, 14'h0005);
    chk_res("R7 CL out of range", 0, 1);
    chk("R7 R12 rejected no state change", int'(bank_open), 0);
    cfg_cl = 3'd4; cfg_al = 3'd6;
    cmd(4, 1, 0);
    chk_res("R7 AL out of range", 0, 1);
    cfg_cl = 3'd5; cfg_al = 3'd2; cfg_bl8 = 1'b1;
    idle(2);
    chk("R7 rd_lat AL+CL", int'(rd_lat), 7);
    chk("R7 wr_lat", int'(wr_lat), 6);
    cmd(1, 3, 14'h0009);                 // a
    cmd(2, 3, 0);                        // a+1
    chk_res("R3 early read with AL", 0, 4);
    cmd(2, 3, 0);                        // a+2 = tRCD-AL
    chk_res("R3 read at tRCD-AL", 1, 0);
    cmd(3, 3, 0);                        // a+3
    chk_res("R8 BL8 spacing", 0, 7);
    idle(1);
    cmd(3, 3, 0);                        // a+5
    chk_res("R8 BL8 spacing last cycle", 0, 7);
    cmd(3, 3, 0);                        // a+6
    chk_res("R8 BL8 write allowed", 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_basic;
    t_autopre;
    t_prea;
    t_refresh;
    t_cfg;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule